// File: doc/BRIEF.md
# Flash Erase Status and Timer

This block sits beside the command decoder of a NOR flash model that uses the classic unlock-cycle command set. It produces the byte that software polls while the array is busy. It also times program, sector erase and chip erase operations. The decoder hands it one-cycle strobes: program data accepted (with bit 7 of the data), sector erase queued (with a sector index), chip erase started, erase suspend, erase resume, and a read strobe that carries the sector index of the address being read. In return the block drives the status byte, a busy flag, a suspended flag, and a one-cycle `done` pulse that tells the decoder to return to read mode. It also drives a select line that tells the read path to return the status byte instead of array data.

Time is counted in microsecond ticks made by a cycle prescaler. The prescaler restarts whenever a new duration is loaded.

Sector erases are collected in an accumulation window. Each accepted sector strobe restarts the window. When the window lapses, the erase-in-progress flag is raised and the erase phase begins. Its length scales with the number of distinct sectors queued. A suspend parks the remaining time, and a resume reloads it.

Top module: `flash_erase_timer`

## Requirements
- R1: After reset, `status` is 0x00 and `busy`, `suspended`, `done` and `stat_sel` are all 0.
- R2: A `prog_stb` while idle makes `busy` 1 and sets status bit 7 to the inverse of `prog_msb`. Each `rd_stb` during a program inverts status bit 6 and leaves bit 2 unchanged. The program ends `PROG_US` ticks after the strobe, and at that point bit 7 equals `prog_msb`.
- R3: Each `rd_stb` during an accumulation window, a sector erase phase or a chip erase inverts both status bit 6 and status bit 2. The new values are visible one cycle after the strobe.
- R4: An accepted `sect_stb` clears status bit 7 and restarts a window of `WINDOW_US` ticks. Status bit 3 stays 0 during the window and becomes 1 in the cycle in which the window expires.
- R5: The sector erase phase lasts (number of distinct flagged sectors) × 2^`ERASE_EXP` × `US_PER_MS` ticks. A repeated strobe for a sector that is already flagged restarts the window but adds no time.
- R6: A `chip_stb` while idle clears status bit 7, leaves bit 3 at 0, and runs for 2^`CHIP_EXP` × `US_PER_MS` ticks.
- R7: On completion of any operation, status bit 7 is inverted, `done` is 1 for exactly one cycle, and `busy` is 0. A completed sector erase also clears bit 3, the sector flags and the sector count.
- R8: A `susp_stb` during the window stops the timer and clears bit 3. It sets `suspended` to 1 and `busy` to 0, and saves the full computed erase time.
- R9: A `susp_stb` during the erase phase saves the ticks still left, with a minimum of 1. If it arrives in the same cycle as the final tick, the suspend wins: no `done` is issued and 1 tick is saved.
- R10: A `resume_stb` while suspended reloads the saved time, sets bit 3, clears bit 7 and sets `busy` to 1.
- R11: While suspended, `stat_sel` is 1 exactly when `rd_sect` names a flagged sector. A `rd_stb` to such a sector inverts bit 2 and leaves bit 6 unchanged. A `rd_stb` to any other sector leaves `status` unchanged.
- R12: During a chip erase, the program, sector and suspend strobes have no effect. During the sector erase phase, a `sect_stb` has no effect on the duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_stb | input | 1 | Program data accepted |
| prog_msb | input | 1 | Bit 7 of the data being programmed |
| sect_stb | input | 1 | Sector erase queued |
| sect_idx | input | $clog2(NUM_SECT) | Sector queued with `sect_stb` |
| chip_stb | input | 1 | Chip erase started |
| susp_stb | input | 1 | Erase suspend |
| resume_stb | input | 1 | Erase resume |
| rd_stb | input | 1 | Read access while not in plain array mode |
| rd_sect | input | $clog2(NUM_SECT) | Sector of the read address |
| status | output | 8 | Polled byte: bit 7 data poll, bit 6 toggle, bit 3 erase started, bit 2 erase toggle |
| busy | output | 1 | Timer running |
| suspended | output | 1 | Erase suspended |
| done | output | 1 | One-cycle completion pulse |
| stat_sel | output | 1 | Read path returns `status` instead of array data |

## Verification
The suspend strobe and the last microsecond tick of the erase phase can land on the same clock edge. The bench provokes this by counting cycles from the sector strobe and placing the suspend exactly on the edge where the remaining count would reach zero. It then judges the outcome on three points: `done` must stay low, `suspended` must rise, and the resumed erase must finish one tick (two cycles with the bench prescaler) after the resume strobe. A second case puts the suspend several ticks into the erase phase and checks that the resumed time equals the remaining time, not the full erase time.

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int NUM_SECT   = 16,
  parameter int CYC_PER_US = 100,
  parameter int US_PER_MS  = 1000,
  parameter int WINDOW_US  = 50,
  parameter int ERASE_EXP  = 9,
  parameter int CHIP_EXP   = 12,
  parameter int PROG_US    = 8,
  localparam int SW = $clog2(NUM_SECT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_stb,
  input  logic          prog_msb,
  input  logic          sect_stb,
  input  logic [SW-1:0] sect_idx,
  input  logic          chip_stb,
  input  logic          susp_stb,
  input  logic          resume_stb,
  input  logic          rd_stb,
  input  logic [SW-1:0] rd_sect,
  output logic [7:0]    status,
  output logic          busy,
  output logic          suspended,
  output logic          done,
  output logic          stat_sel
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int CW = $clog2(NUM_SECT + 1);
  localparam int TW = 32;

  typedef enum logic [2:0] {M_IDLE, M_PROG, M_WIN, M_ERASE, M_CHIP, M_SUSP} mode_t;

  mode_t               mode;
  logic [PW-1:0]       pre;
  logic [TW-1:0]       rem, saved;
  logic [CW-1:0]       cnt;
  logic [NUM_SECT-1:0] flags;
  logic                dq7, dq6, dq3, dq2;

  logic running, tick, expire, susp_ok, sect_ok, new_sect;
  logic [TW-1:0] erase_full, chip_time;

  assign running    = (mode == M_PROG) || (mode == M_WIN) || (mode == M_ERASE) || (mode == M_CHIP);
  assign tick       = running && (pre == PW'(CYC_PER_US - 1));
  assign expire     = tick && (rem == TW'(1));
  assign susp_ok    = susp_stb && ((mode == M_WIN) || (mode == M_ERASE));
  assign sect_ok    = sect_stb && ((mode == M_IDLE) || (mode == M_WIN));
  assign new_sect   = !flags[sect_idx];
  assign erase_full = (TW'(cnt) * TW'(US_PER_MS)) << ERASE_EXP;
  assign chip_time  = TW'(US_PER_MS) << CHIP_EXP;

  assign status     = {dq7, dq6, 2'b00, dq3, dq2, 2'b00};
  assign busy       = running;
  assign suspended  = (mode == M_SUSP);
  assign stat_sel   = running || (suspended && flags[rd_sect]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= M_IDLE;
      pre   <= '0;
      rem   <= '0;
      saved <= '0;
      cnt   <= '0;
      flags <= '0;
      dq7   <= 1'b0;
      dq6   <= 1'b0;
      dq3   <= 1'b0;
      dq2   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      pre  <= running ? (tick ? '0 : pre + 1'b1) : '0;
      if (tick) rem <= rem - 1'b1;

      if (susp_ok) begin
        saved <= (mode == M_WIN) ? erase_full : ((rem == '0) ? TW'(1) : rem);
        dq3   <= 1'b0;
        mode  <= M_SUSP;
        pre   <= '0;
      end else if (sect_ok) begin
        dq7            <= 1'b0;
        flags[sect_idx] <= 1'b1;
        cnt            <= cnt + CW'(new_sect);
        rem            <= TW'(WINDOW_US);
        pre            <= '0;
        mode           <= M_WIN;
      end else if (expire) begin
        if (mode == M_WIN) begin
          dq3  <= 1'b1;
          rem  <= erase_full;
          pre  <= '0;
          mode <= M_ERASE;
        end else begin
          dq7  <= ~dq7;
          done <= 1'b1;
          mode <= M_IDLE;
          if (mode == M_ERASE) begin
            dq3   <= 1'b0;
            flags <= '0;
            cnt   <= '0;
          end
        end
      end else if (resume_stb && mode == M_SUSP) begin
        rem   <= saved;
        saved <= '0;
        dq3   <= 1'b1;
        dq7   <= 1'b0;
        pre   <= '0;
        mode  <= M_ERASE;
      end else if (prog_stb && mode == M_IDLE) begin
        dq7  <= ~prog_msb;
        rem  <= TW'(PROG_US);
        pre  <= '0;
        mode <= M_PROG;
      end else if (chip_stb && mode == M_IDLE) begin
        dq7  <= 1'b0;
        rem  <= chip_time;
        pre  <= '0;
        mode <= M_CHIP;
      end

      if (rd_stb) begin
        case (mode)
          M_PROG: dq6 <= ~dq6;
          M_WIN, M_ERASE, M_CHIP: begin
            dq6 <= ~dq6;
            dq2 <= ~dq2;
          end
          M_SUSP: if (flags[rd_sect]) dq2 <= ~dq2;
          default: ;
        endcase
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cnt == '0 && !status[3]));

  // R8
  susp_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (!status[3] && !busy));

  // R10
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_stb && suspended) |=> (busy && status[3] && !status[7]));

  // R2
  prog_dq7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb && !busy && !suspended && !sect_stb) |=> (status[7] == !$past(prog_msb)));

  // R11
  susp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && rd_stb && !stat_sel && !resume_stb) |=> $stable(status));

  // R9
  susp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_stb && busy && status[3]) |=> (suspended && !done));
endmodule

// File: tb/flash_erase_timer_tb_top.sv
`timescale 1ns/1ps
module flash_erase_timer_tb_top;
  localparam int NS = 8;
  localparam int SW = $clog2(NS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_stb = 0, prog_msb = 0, sect_stb = 0, chip_stb = 0;
  logic susp_stb = 0, resume_stb = 0, rd_stb = 0;
  logic [SW-1:0] sect_idx = '0, rd_sect = '0;
  logic [7:0] status;
  logic busy, suspended, done, stat_sel;

  int checks = 0;
  int fails = 0;
  int k = 0;

  always #2.5 clk = ~clk;

  flash_erase_timer #(
    .NUM_SECT(NS), .CYC_PER_US(2), .US_PER_MS(4), .WINDOW_US(5),
    .ERASE_EXP(2), .CHIP_EXP(3), .PROG_US(3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_stb(prog_stb), .prog_msb(prog_msb),
    .sect_stb(sect_stb), .sect_idx(sect_idx), .chip_stb(chip_stb),
    .susp_stb(susp_stb), .resume_stb(resume_stb), .rd_stb(rd_stb),
    .rd_sect(rd_sect), .status(status), .busy(busy), .suspended(suspended),
    .done(done), .stat_sel(stat_sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic do_prog(input logic b);
    prog_stb = 1; prog_msb = b; step(1); prog_stb = 0;
  endtask
  task automatic do_sect(input int s);
    sect_stb = 1; sect_idx = SW'(s); step(1); sect_stb = 0;
  endtask
  task automatic do_chip();
    chip_stb = 1; step(1); chip_stb = 0;
  endtask
  task automatic do_susp();
    susp_stb = 1; step(1); susp_stb = 0;
  endtask
  task automatic do_resume();
    resume_stb = 1; step(1); resume_stb = 0;
  endtask
  task automatic do_rd(input int s);
    rd_stb = 1; rd_sect = SW'(s); step(1); rd_stb = 0;
  endtask

  task automatic wait_done(input int limit);
    while (!done && k < limit) step(1);
  endtask

  task automatic t_reset();
    check("R1 status", status, 0);
    check("R1 busy", busy, 0);
    check("R1 suspended", suspended, 0);
    check("R1 done", done, 0);
    check("R1 stat_sel", stat_sel, 0);
  endtask

  task automatic t_program();
    logic b6, b2;
    do_prog(1'b1); k = 0;
    check("R2 dq7 while busy", status[7], 0);
    check("R2 busy", busy, 1);
    b6 = status[6]; b2 = status[2];
    do_rd(0);
    check("R2 dq6 toggles", status[6], int'(!b6));
    check("R2 dq2 held", status[2], int'(b2));
    wait_done(100);
    check("R2 program length", k, 6);
    check("R2 dq7 after done", status[7], 1);
    check("R7 busy low at done", busy, 0);
    step(1);
    check("R7 done one cycle", done, 0);
  endtask

  task automatic t_sector_one();
    logic b6, b2;
    do_sect(2); k = 0;
    check("R4 dq7 cleared", status[7], 0);
    step(9);
    check("R4 dq3 low in window", status[3], 0);
    step(1);
    check("R4 dq3 set at expiry", status[3], 1);
    b6 = status[6]; b2 = status[2];
    do_rd(2);
    check("R3 dq6 toggles in erase", status[6], int'(!b6));
    check("R3 dq2 toggles in erase", status[2], int'(!b2));
    do_sect(6);
    wait_done(200);
    check("R5 R12 one sector erase length", k, 42);
    check("R7 dq7 inverted", status[7], 1);
    check("R7 dq3 cleared", status[3], 0);
  endtask

  task automatic t_two_sectors();
    do_sect(1); step(3);
    do_sect(3); k = 0;
    wait_done(300);
    check("R5 two sector length", k, 74);
    do_sect(4); step(3);
    do_sect(4); k = 0;
    wait_done(300);
    check("R5 repeated sector adds no time", k, 42);
  endtask

  task automatic t_susp_window();
    logic [7:0] st;
    do_sect(5); step(3);
    do_susp();
    check("R8 suspended", suspended, 1);
    check("R8 busy low", busy, 0);
    check("R8 dq3 cleared", status[3], 0);
    rd_sect = SW'(1); #1;
    check("R7 old flag cleared", stat_sel, 0);
    rd_sect = SW'(5); #1;
    check("R11 stat_sel flagged", stat_sel, 1);
    st = status;
    do_rd(5);
    check("R11 dq2 toggles", status[2], int'(!st[2]));
    check("R11 dq6 held", status[6], int'(st[6]));
    st = status;
    do_rd(1);
    check("R11 other sector untouched", status, st);
    k = 0;
    while (k < 20) begin
      step(1);
      if (done) check("R8 no done while suspended", 1, 0);
    end
    check("R8 still suspended", suspended, 1);
    do_resume(); k = 0;
    check("R10 busy", busy, 1);
    check("R10 dq3 set", status[3], 1);
    check("R10 dq7 cleared", status[7], 0);
    wait_done(200);
    check("R8 full time restored", k, 32);
  endtask

  task automatic t_susp_late();
    do_sect(0); k = 0;
    step(19);
    do_susp();
    check("R9 suspended", suspended, 1);
    check("R9 dq3 cleared", status[3], 0);
    do_resume(); k = 0;
    wait_done(200);
    check("R9 remaining time", k, 24);
  endtask

  task automatic t_final_tick();
    do_sect(0); k = 0;
    step(41);
    do_susp();
    check("R9 no done on final tick", done, 0);
    check("R9 suspend wins", suspended, 1);
    do_resume(); k = 0;
    wait_done(50);
    check("R9 one tick left", k, 2);
  endtask

  task automatic t_chip();
    logic b6, b2;
    do_chip(); k = 0;
    check("R6 dq7 cleared", status[7], 0);
    check("R6 busy", busy, 1);
    b6 = status[6]; b2 = status[2];
    do_rd(0);
    check("R3 chip dq6", status[6], int'(!b6));
    check("R3 chip dq2", status[2], int'(!b2));
    step(9);
    do_prog(1'b0);
    check("R12 prog ignored", status[7], 0);
    do_sect(4);
    do_susp();
    check("R12 susp ignored", suspended, 0);
    step(10);
    check("R12 sect ignored dq3", status[3], 0);
    wait_done(300);
    check("R6 chip length", k, 64);
    check("R6 dq7 after chip", status[7], 1);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_program();
    t_sector_one();
    t_two_sectors();
    t_susp_window();
    t_susp_late();
    t_final_tick();
    t_chip();
    step(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule